// File: doc/BRIEF.md
# HDLC Frame Receiver with Stored Check Bytes

This block takes a serial bit stream, qualified by a bit-enable strobe, and recovers HDLC frames from it. It hunts for the flag octet, removes the zero bits that the sender inserted after runs of five ones, and assembles the payload into bytes with the least significant bit first. It runs the 16-bit ITU-T frame check over every frame and appends one status byte to each frame in a receive FIFO.

A mode input selects what the FIFO keeps. With the mode clear, the two check bytes are consumed and only the payload and the status byte are stored. With the mode set, the two check bytes are stored as received, and the status byte follows them. The check result is reported in both modes.

The host sees the FIFO as a sequence of blocks. A 2-bit field picks the block size. A block is offered either when that many bytes are present, or earlier when a status byte lies inside it. The host reads the block through a byte port and then hands it back with a release pulse.

Top module: `hdlc_crc_rx`

## Requirements
- R1: After reset, `blk_irq` and `eof_irq` are low, `blk_cnt` is 0 and the block size is 32 bytes.
- R2: The pattern 0x7E, received least significant bit first, opens and closes frames. A zero that follows five ones inside a frame is removed. Payload bytes reach the FIFO in arrival order, each assembled with the first received bit in bit 0.
- R3: Each frame ends with a status byte. Bit 7 is 1 only if the check register, preset to 0xFFFF and run over the payload and both check bytes with the reflected polynomial x^16+x^12+x^5+1, ends at 0xF0B8, and the frame ends on a byte boundary. Bit 6 marks an abort, bit 5 marks an overflow and bits 4..0 are 0.
- R4: With `crc_keep` low, the FIFO gets payload, then status. With `crc_keep` high, it gets payload, the two check bytes in received order, then status, and bit 7 still reports the check.
- R5: `thr_sel` selects the block size: 00 gives 32, 01 gives 16, 10 gives 4 and 11 gives 2. `blk_irq` rises when that many bytes are unread in the current block and none of them is a status byte. `blk_cnt` then equals the size.
- R6: `eof_irq` rises when a status byte lies within the first block-size bytes of the current block. `blk_cnt` is then the byte count up to and including that status byte.
- R7: Each `rd_en` cycle advances `rd_data` by one byte of the offered block. `release_blk` while a block is offered discards that block. `release_blk` with no block offered is ignored.
- R8: A new `thr_sel` value is taken only at an accepted release, or while the FIFO is empty and the current frame has no bytes yet. While a block is offered, its count does not change until it is released.
- R9: Seven ones inside a frame that already has at least one byte abort that frame. The two most recent bytes, which are held back as possible check bytes, are dropped. A status byte of 0x40 is stored, and the receiver returns to hunting.
- R10: A payload byte is stored only while at least 4 FIFO entries are free. Otherwise the frame is marked with bit 5, and its remaining payload and check bytes are dropped. The status byte is still stored.
- R11: Cycles with `rx_en` low have no effect, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Serial receive data |
| rx_en | input | 1 | Bit-enable strobe; `rx_bit` is taken when high |
| crc_keep | input | 1 | Store the received check bytes ahead of the status byte |
| thr_sel | input | 2 | Block size selection |
| rd_en | input | 1 | Advance to the next byte of the offered block |
| rd_data | output | 8 | Current byte of the offered block |
| release_blk | input | 1 | Hand the offered block back to the FIFO |
| blk_irq | output | 1 | A full-size block without frame end is ready |
| eof_irq | output | 1 | A block ending in a status byte is ready |
| blk_cnt | output | 6 | Byte count of the offered block, 0 when none is offered |

## Verification
The properties assume that `release_blk` is a single-cycle pulse issued only after the offered bytes have been read. They also assume that `rd_en` is never raised for more bytes than `blk_cnt` reports, and that `crc_keep` is changed only while no frame is in progress. The stimulus respects these assumptions. The host model reads exactly `blk_cnt` bytes before each release. The mode and the block size are changed only after the FIFO has drained and idle ones have ended any frame, with one exception. In that case the block size is deliberately changed while a block is being offered, to show that the offered count holds until release. Every strobed bit is followed by a cycle in which the strobe is low and the data line carries the inverted bit.

// File: rtl/hdlc_crc_rx.sv
module hdlc_crc_rx #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_en,
  input  logic       crc_keep,
  input  logic [1:0] thr_sel,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       release_blk,
  output logic       blk_irq,
  output logic       eof_irq,
  output logic [5:0] blk_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int MAXB = 32;
  localparam logic [15:0] RESIDUE = 16'hF0B8;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  logic [2:0]  ones, bitcnt;
  logic        in_frame, got, ovf;
  logic [6:0]  sh;
  logic [7:0]  h0, h1;
  logic [1:0]  hcnt;
  logic [15:0] crc;
  logic [8:0]  mem [DEPTH];
  logic [AW:0] wp, base, rofs, fill, free, bsize, k, blen;
  logic [1:0]  cur_thr, wn;
  logic [8:0]  wd [3];
  logic        found, set_ovf;

  wire [7:0] new_byte = {rx_bit, sh};
  wire is_flag  = rx_en & ~rx_bit & (ones == 3'd6);
  wire is_stuff = rx_en & ~rx_bit & (ones == 3'd5) & in_frame;
  wire is_abort = rx_en & rx_bit & (ones == 3'd6) & in_frame;
  wire emit     = rx_en & in_frame & ~is_flag & ~is_stuff & ~(rx_bit & (ones >= 3'd6));
  wire byte_done = emit & (bitcnt == 3'd7);
  wire close = is_flag & in_frame & got;
  wire abrt  = is_abort & got;
  wire good  = (crc == RESIDUE) && (bitcnt == 3'd7);
  wire keep_fcs = crc_keep && !ovf && (hcnt == 2'd2) && (free >= (AW+1)'(3));
  wire ovf_c = ovf || (crc_keep && (hcnt == 2'd2) && (free < (AW+1)'(3)));
  wire ready = blk_irq | eof_irq;

  assign fill = wp - base;
  assign free = (AW+1)'(DEPTH) - fill;

  always_comb begin
    wn = '0;
    wd[0] = '0;
    wd[1] = '0;
    wd[2] = '0;
    set_ovf = 1'b0;
    if (byte_done && hcnt == 2'd2 && !ovf) begin
      if (free >= (AW+1)'(4)) begin
        wn = 2'd1;
        wd[0] = {1'b0, h1};
      end else set_ovf = 1'b1;
    end
    if (close) begin
      if (keep_fcs) begin
        wn = 2'd3;
        wd[0] = {1'b0, h1};
        wd[1] = {1'b0, h0};
        wd[2] = {1'b1, good, 2'b00, 5'd0};
      end else if (free != '0) begin
        wn = 2'd1;
        wd[0] = {1'b1, good, 1'b0, ovf_c, 5'd0};
      end
    end else if (abrt && free != '0) begin
      wn = 2'd1;
      wd[0] = {1'b1, 1'b0, 1'b1, ovf, 5'd0};
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++)
      if (i < int'(wn)) mem[wp[AW-1:0] + AW'(i)] <= wd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0;
      in_frame <= 1'b0;
      got <= 1'b0;
      ovf <= 1'b0;
      bitcnt <= '0;
      sh <= '0;
      h0 <= '0;
      h1 <= '0;
      hcnt <= '0;
      crc <= 16'hFFFF;
      wp <= '0;
    end else begin
      if (rx_en) ones <= rx_bit ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
      if (is_flag) begin
        in_frame <= 1'b1;
        got <= 1'b0;
        ovf <= 1'b0;
        bitcnt <= '0;
        hcnt <= '0;
        crc <= 16'hFFFF;
      end else if (is_abort) begin
        in_frame <= 1'b0;
      end else if (emit) begin
        sh <= new_byte[7:1];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          got <= 1'b1;
          crc <= crc_step(crc, new_byte);
          h1 <= h0;
          h0 <= new_byte;
          hcnt <= (hcnt == 2'd2) ? 2'd2 : hcnt + 2'd1;
          if (set_ovf) ovf <= 1'b1;
        end
      end
      wp <= wp + (AW+1)'(wn);
    end
  end

  always_comb begin
    case (cur_thr)
      2'd0:    bsize = (AW+1)'(32);
      2'd1:    bsize = (AW+1)'(16);
      2'd2:    bsize = (AW+1)'(4);
      default: bsize = (AW+1)'(2);
    endcase
    found = 1'b0;
    k = '0;
    for (int i = 0; i < MAXB; i++)
      if (!found && i < int'(bsize) && i < int'(fill) && mem[base[AW-1:0] + AW'(i)][8]) begin
        found = 1'b1;
        k = (AW+1)'(i);
      end
  end

  assign eof_irq = found;
  assign blk_irq = !found && (fill >= bsize);
  assign blen = found ? k + (AW+1)'(1) : bsize;
  assign blk_cnt = ready ? 6'(blen) : 6'd0;
  assign rd_data = mem[base[AW-1:0] + rofs[AW-1:0]][7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      rofs <= '0;
      cur_thr <= 2'd0;
    end else if (release_blk && ready) begin
      base <= base + blen;
      rofs <= '0;
      cur_thr <= thr_sel;
    end else begin
      if (rd_en && ready) rofs <= rofs + (AW+1)'(1);
      if (fill == '0 && !got) cur_thr <= thr_sel;
    end
  end
endmodule

module hdlc_crc_rx_chk #(
  parameter int DEPTH = 64,
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        release_blk,
  input logic        blk_irq,
  input logic        eof_irq,
  input logic [5:0]  blk_cnt,
  input logic [AW:0] wp,
  input logic [AW:0] base
);
  // R8
  hold_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_irq || eof_irq) && !release_blk |=> (blk_irq || eof_irq) && $stable(blk_cnt));
  // R5
  blk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |-> (blk_cnt == 6'd2 || blk_cnt == 6'd4 || blk_cnt == 6'd16 || blk_cnt == 6'd32));
  // R6
  eof_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_irq |-> (blk_cnt != 6'd0 && blk_cnt <= 6'd32));
  // R7
  rel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_blk && !blk_irq && !eof_irq |=> $stable(base));
  // R11
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(wp));
  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AW+1)'(wp - base) <= (AW+1)'(DEPTH));
endmodule

bind hdlc_crc_rx hdlc_crc_rx_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .release_blk(release_blk),
  .blk_irq(blk_irq), .eof_irq(eof_irq), .blk_cnt(blk_cnt), .wp(wp), .base(base)
);

// File: tb/hdlc_crc_rx_tb_top.sv
module hdlc_crc_rx_tb_top;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b1, rx_en = 1'b0;
  logic crc_keep = 1'b0, rd_en = 1'b0, release_blk = 1'b0;
  logic [1:0] thr_sel = 2'd0;
  logic [7:0] rd_data;
  logic blk_irq, eof_irq;
  logic [5:0] blk_cnt;

  hdlc_crc_rx #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en), .crc_keep(crc_keep),
    .thr_sel(thr_sel), .rd_en(rd_en), .rd_data(rd_data), .release_blk(release_blk),
    .blk_irq(blk_irq), .eof_irq(eof_irq), .blk_cnt(blk_cnt)
  );

  always #4 clk = ~clk;

  typedef struct { logic [8:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] fr[$];
  int n_chk = 0, n_bad = 0, run = 0;
  logic [1:0] bthr = 2'd0, chg_val = 2'd0;
  bit mon_pause = 1'b0, mon_busy = 1'b0, chg_req = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int size_of(input logic [1:0] t);
    case (t)
      2'd0: return 32;
      2'd1: return 16;
      2'd2: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] fcs_of(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i])
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ q[i][b]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return ~c;
  endfunction

  // R11: every strobed bit is followed by an unstrobed cycle carrying the inverse
  task automatic send_raw(input logic b);
    @(negedge clk);
    rx_bit = b;
    rx_en = 1'b1;
    @(negedge clk);
    rx_en = 1'b0;
    rx_bit = ~b;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw(i == 0 || i == 7 ? 1'b0 : 1'b1);
    run = 0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      send_raw(d[i]);
      if (d[i]) begin
        run++;
        if (run == 5) begin
          send_raw(1'b0);
          run = 0;
        end
      end else run = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) send_raw(1'b1);
    run = 0;
  endtask

  // mode: 0 normal, 1 bad check, 2 abort, 3 overflow
  task automatic send_frame(input int mode);
    logic [15:0] f;
    f = fcs_of(fr);
    if (mode == 1) f = f ^ 16'h0001;
    if (mode == 2) begin
      for (int i = 0; i < fr.size() - 2; i++) exp_q.push_back('{{1'b0, fr[i]}, "R2 R11 payload"});
      exp_q.push_back('{{1'b1, 8'h40}, "R9 abort status"});
    end else if (mode == 3) begin
      for (int i = 0; i < DEPTH - 3; i++) exp_q.push_back('{{1'b0, fr[i]}, "R10 kept payload"});
      exp_q.push_back('{{1'b1, 8'hA0}, "R10 overflow status"});
    end else begin
      foreach (fr[i]) exp_q.push_back('{{1'b0, fr[i]}, "R2 R11 payload"});
      if (crc_keep) begin
        exp_q.push_back('{{1'b0, f[7:0]}, "R4 stored check low"});
        exp_q.push_back('{{1'b0, f[15:8]}, "R4 stored check high"});
      end
      exp_q.push_back('{{1'b1, (mode == 1) ? 8'h00 : 8'h80}, "R3 status"});
    end
    send_flag();
    foreach (fr[i]) send_byte(fr[i]);
    if (mode == 2) begin
      send_raw(1'b0);
      repeat (7) send_raw(1'b1);
    end else begin
      send_byte(f[7:0]);
      send_byte(f[15:8]);
      send_flag();
    end
    idle(8);
  endtask

  task automatic mkframe(input int n, input int seed);
    fr = {};
    for (int i = 0; i < n; i++) fr.push_back(8'(i * 37 + seed));
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_thr(input logic [1:0] t);
    thr_sel = t;
    bthr = t;
    repeat (2) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    int bsz, len;
    bit eof_e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if ((blk_irq || eof_irq) && !mon_pause) begin
        mon_busy = 1'b1;
        bsz = size_of(bthr);
        eof_e = 1'b0;
        len = bsz;
        for (int i = 0; i < bsz && i < exp_q.size(); i++)
          if (exp_q[i].v[8]) begin
            eof_e = 1'b1;
            len = i + 1;
            break;
          end
        if (!eof_e && exp_q.size() < bsz) chk(1'b0, "R5 block beyond expected data", exp_q.size(), bsz);
        chk(eof_irq == eof_e, "R6 block kind", eof_irq, eof_e);
        chk(blk_cnt == len, eof_e ? "R6 frame-end count" : "R5 block count", blk_cnt, len);
        if (chg_req) begin
          thr_sel = chg_val;
          chg_req = 1'b0;
          repeat (2) @(negedge clk);
          chk(blk_cnt == len, "R8 offered count kept", blk_cnt, len);
        end
        for (int j = 0; j < len; j++) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 read past expected data", j, len);
            break;
          end
          e = exp_q.pop_front();
          chk(rd_data == e.v[7:0], e.tag, rd_data, e.v[7:0]);
          rd_en = 1'b1;
          @(negedge clk);
          rd_en = 1'b0;
        end
        release_blk = 1'b1;
        @(negedge clk);
        release_blk = 1'b0;
        bthr = thr_sel;
        mon_busy = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    chk(!blk_irq && !eof_irq, "R1 no request in reset", {blk_irq, eof_irq}, 0);
    chk(blk_cnt == 0, "R1 count in reset", blk_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!blk_irq && !eof_irq && blk_cnt == 0, "R1 idle after reset", blk_cnt, 0);

    release_blk = 1'b1;
    @(negedge clk);
    release_blk = 1'b0;
    repeat (2) @(negedge clk);
    chk(!blk_irq && !eof_irq && blk_cnt == 0, "R7 stray release ignored", blk_cnt, 0);
    idle(10);

    fr = {8'h7E, 8'hFF, 8'h3E, 8'h00, 8'hF8, 8'h1F};
    send_frame(0);
    drain();
    mkframe(40, 3);
    send_frame(0);
    drain();

    crc_keep = 1'b1;
    mkframe(6, 11);
    send_frame(0);
    mkframe(5, 90);
    send_frame(1);
    drain();
    crc_keep = 1'b0;
    mkframe(7, 5);
    send_frame(1);
    drain();

    set_thr(2'd1);
    mkframe(20, 17);
    send_frame(0);
    drain();
    set_thr(2'd2);
    mkframe(9, 23);
    send_frame(0);
    drain();
    set_thr(2'd3);
    mkframe(5, 29);
    send_frame(0);
    drain();

    set_thr(2'd2);
    chg_val = 2'd1;
    chg_req = 1'b1;
    mkframe(12, 41);
    send_frame(0);
    drain();

    set_thr(2'd0);
    mkframe(6, 55);
    send_frame(2);
    drain();

    mon_pause = 1'b1;
    crc_keep = 1'b1;
    mkframe(80, 61);
    send_frame(3);
    repeat (4) @(negedge clk);
    chk(blk_irq && blk_cnt == 32, "R10 full block waiting", blk_cnt, 32);
    mon_pause = 1'b0;
    drain();
    crc_keep = 1'b0;

    chk(exp_q.size() == 0 && !blk_irq && !eof_irq, "R7 all blocks consumed", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule